// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block converts a real-mode logical address, written as a segment and a 16-bit offset, into a 20-bit physical address. It holds four 16-bit segment registers: code, data, stack and extra. A synchronous write port loads them. Each translation request carries three things: the effective offset, a tag that names the base or pointer register that produced the offset, and an optional segment override. The block picks the segment, shifts its value left by four bits and adds the offset. Any carry out of the 20-bit result is dropped, so addresses near the top of memory wrap to the bottom.

The output address and its valid strobe are registered and appear one clock after the request. The same physical address can be reached through many different segment and offset pairs, and the block treats every one of them as an ordinary translation. A segment register written on one clock edge is used by requests presented in the following cycle. A request sampled on the same edge as the write still sees the old value.

Top module: `seg_xlate`

## Requirements
- R1: While `rst` is high, on each clock edge `out_valid` is cleared, `out_addr` is cleared to 00000h and all four segment registers are cleared to 0000h. After reset, a request therefore returns its offset unchanged as the address.
- R2: `out_valid` is high in the cycle after every cycle in which `req_valid` is high, and low in the cycle after every cycle in which `req_valid` is low. Back-to-back requests give back-to-back results.
- R3: The physical address is (segment << 4) + offset, taken modulo 2^20. The carry out of bit 19 is discarded. For example, segment FF59h with offset FFFFh gives 0F58Fh.
- R4: A request tagged as an instruction fetch (`req_src` = 0) always uses the code segment. `ovr_en` and `ovr_sel` are ignored for it.
- R5: Without an override, a request tagged stack pointer (`req_src` = 1) or base pointer (`req_src` = 2) uses the stack segment.
- R6: Without an override, requests tagged 3, 4 or 5 (base index, source index, destination index) use the data segment. The unused tags 6 and 7 also use the data segment.
- R7: When `ovr_en` is high and the request is not a fetch, `ovr_sel` picks the segment: 0 = code, 1 = data, 2 = stack, 3 = extra.
- R8: `wr_en` loads `wr_data` into the segment register named by `wr_sel`, using the same 0–3 encoding as R7. A request in the same cycle as the write uses the old value. A request in any later cycle uses the new value.
- R9: Two different segment:offset pairs that name the same location both produce a valid result with identical addresses. No error is raised.
- R10: In a cycle with no request, `out_addr` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Segment register write enable |
| wr_sel | input | 2 | Segment to write (0 code, 1 data, 2 stack, 3 extra) |
| wr_data | input | 16 | New segment value |
| req_valid | input | 1 | Translation request strobe |
| req_offset | input | 16 | Effective offset |
| req_src | input | 3 | Register that formed the offset (0 IP, 1 SP, 2 BP, 3 BX, 4 SI, 5 DI) |
| ovr_en | input | 1 | Segment override present |
| ovr_sel | input | 2 | Override segment (0 code, 1 data, 2 stack, 3 extra) |
| out_valid | output | 1 | Physical address valid |
| out_addr | output | 20 | 20-bit physical address |

## Verification
A segment register holding a wrong value, or a wrong segment selection, appears on `out_addr` one cycle after the first request that uses that register. Such an address is off by a multiple of 16 bytes. For this reason the stimulus gives each of the four segments a distinct value, and a mis-steered selection cannot produce the expected address by accident. A write-timing fault shows up on the request issued in the same cycle as the write, or on the request in the cycle right after it. A lost carry-discard shows up only on sums above FFFFFh, so the stimulus includes sums that land exactly on 100000h and above it.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  localparam int SEG_COUNT = 4;

  typedef enum logic [1:0] {
    SEG_CODE  = 2'd0,
    SEG_DATA  = 2'd1,
    SEG_STACK = 2'd2,
    SEG_EXTRA = 2'd3
  } seg_id_e;

  typedef enum logic [2:0] {
    SRC_IP   = 3'd0,
    SRC_SP   = 3'd1,
    SRC_BP   = 3'd2,
    SRC_BX   = 3'd3,
    SRC_SI   = 3'd4,
    SRC_DI   = 3'd5,
    SRC_RSV6 = 3'd6,
    SRC_RSV7 = 3'd7
  } off_src_e;
endpackage

// File: rtl/seg_regfile.sv
module seg_regfile #(
  parameter int SEG_W = 16,
  parameter int NUM   = 4,
  localparam int SEL_W = $clog2(NUM)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [SEL_W-1:0]          wr_sel,
  input  logic [SEG_W-1:0]          wr_data,
  output logic [NUM-1:0][SEG_W-1:0] rd_all
);
  // One register per segment; the read happens before the edge, so a
  // same-cycle request sees the old contents (R8).
  for (genvar g = 0; g < NUM; g++) begin : g_seg
    logic [SEG_W-1:0] val_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        val_q <= '0;
      end else if (wr_en && (wr_sel == SEL_W'(g))) begin
        val_q <= wr_data;
      end
    end
    assign rd_all[g] = val_q;
  end
endmodule

// File: rtl/seg_pick.sv
module seg_pick
  import seg_xlate_pkg::*;
(
  input  logic [2:0] src,
  input  logic       ovr_en,
  input  logic [1:0] ovr_sel,
  output logic [1:0] sel
);
  off_src_e src_e;
  seg_id_e  dflt;

  assign src_e = off_src_e'(src);

  always_comb begin
    unique case (src_e)
      SRC_IP:         dflt = SEG_CODE;
      SRC_SP, SRC_BP: dflt = SEG_STACK;
      default:        dflt = SEG_DATA;
    endcase
  end

  // Fetches are pinned to the code segment; everything else may be overridden.
  always_comb begin
    if (src_e == SRC_IP) begin
      sel = SEG_CODE;
    end else if (ovr_en) begin
      sel = ovr_sel;
    end else begin
      sel = dflt;
    end
  end
endmodule

// File: rtl/seg_shift_add.sv
module seg_shift_add #(
  parameter int SEG_W  = 16,
  parameter int OFF_W  = 16,
  parameter int SHIFT  = 4,
  localparam int ADDR_W = SEG_W + SHIFT
) (
  input  logic [SEG_W-1:0]  seg,
  input  logic [OFF_W-1:0]  off,
  output logic [ADDR_W-1:0] addr
);
  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] off_ext;

  assign base    = {seg, {SHIFT{1'b0}}};
  assign off_ext = {{(ADDR_W-OFF_W){1'b0}}, off};
  // Result width equals ADDR_W: the carry out of the top bit is dropped.
  assign addr    = base + off_ext;
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate #(
  parameter int SEG_W = 16,
  parameter int OFF_W = 16,
  parameter int SHIFT = 4,
  localparam int ADDR_W = SEG_W + SHIFT,
  localparam int NSEG   = seg_xlate_pkg::SEG_COUNT,
  localparam int SEL_W  = $clog2(NSEG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [SEG_W-1:0]  wr_data,
  input  logic              req_valid,
  input  logic [OFF_W-1:0]  req_offset,
  input  logic [2:0]        req_src,
  input  logic              ovr_en,
  input  logic [SEL_W-1:0]  ovr_sel,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_addr
);
  logic [NSEG-1:0][SEG_W-1:0] segs;
  logic [1:0]                 pick;
  logic [SEG_W-1:0]           seg_val;
  logic [ADDR_W-1:0]          sum;

  seg_regfile #(.SEG_W(SEG_W), .NUM(NSEG)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .rd_all  (segs)
  );

  seg_pick u_pick (
    .src     (req_src),
    .ovr_en  (ovr_en),
    .ovr_sel (ovr_sel),
    .sel     (pick)
  );

  assign seg_val = segs[pick];

  seg_shift_add #(.SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT)) u_add (
    .seg  (seg_val),
    .off  (req_offset),
    .addr (sum)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
    end else begin
      out_valid <= req_valid;
      if (req_valid) begin
        out_addr <= sum;
      end
    end
  end
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
  parameter int SEG_W  = 16,
  parameter int OFF_W  = 16,
  parameter int SHIFT  = 4,
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [1:0]        wr_sel,
  input logic [SEG_W-1:0]  wr_data,
  input logic              req_valid,
  input logic [OFF_W-1:0]  req_offset,
  input logic [2:0]        req_src,
  input logic              ovr_en,
  input logic [1:0]        ovr_sel,
  input logic              out_valid,
  input logic [ADDR_W-1:0] out_addr
);
  // Shadow segment values tracked from the write port alone.
  logic [SEG_W-1:0]  sh [4];
  logic [ADDR_W-1:0] ex [4];
  logic [ADDR_W-1:0] ex_ovr;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 4; i++) sh[i] <= '0;
    end else if (wr_en) begin
      sh[wr_sel] <= wr_data;
    end
  end

  always_comb begin
    for (int i = 0; i < 4; i++) begin
      ex[i] = ADDR_W'({sh[i], {SHIFT{1'b0}}}) + ADDR_W'(req_offset);
    end
  end
  assign ex_ovr = ex[ovr_sel];

  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (!out_valid && out_addr == '0));

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> out_valid);

  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !out_valid);

  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> $stable(out_addr));

  a_r4_fetch_code: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_src == 3'd0) |=> out_addr == $past(ex[0]));

  a_r5_stack_default: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !ovr_en && (req_src == 3'd1 || req_src == 3'd2))
      |=> out_addr == $past(ex[2]));

  a_r6_data_default: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !ovr_en && req_src >= 3'd3) |=> out_addr == $past(ex[1]));

  a_r7_override: assert property (@(posedge clk) disable iff (rst)
    (req_valid && ovr_en && req_src != 3'd0) |=> out_addr == $past(ex_ovr));
endmodule

bind seg_xlate seg_xlate_chk #(
  .SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT), .ADDR_W(ADDR_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .wr_en      (wr_en),
  .wr_sel     (wr_sel),
  .wr_data    (wr_data),
  .req_valid  (req_valid),
  .req_offset (req_offset),
  .req_src    (req_src),
  .ovr_en     (ovr_en),
  .ovr_sel    (ovr_sel),
  .out_valid  (out_valid),
  .out_addr   (out_addr)
);

// File: tb/sim_seg_xlate.sv
`timescale 1ns/1ps
module sim_seg_xlate;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [15:0] wr_data = '0;
  logic        req_valid = 1'b0;
  logic [15:0] req_offset = '0;
  logic [2:0]  req_src = '0;
  logic        ovr_en = 1'b0;
  logic [1:0]  ovr_sel = '0;
  logic        out_valid;
  logic [19:0] out_addr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  seg_xlate u0 (.*);

  typedef struct packed {
    logic [2:0]  src;
    logic        oe;
    logic [1:0]  os;
    logic [15:0] off;
    logic [19:0] exp;
    logic [3:0]  tag;
  } vec_t;

  // Segments loaded before the table: code 2500h, data FF59h, stack 1502h, extra 1000h.
  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{3'd0, 1'b0, 2'd0, 16'h95F3, 20'h2E5F3, 4'd4}, // R4 fetch
    '{3'd0, 1'b1, 2'd3, 16'h95F3, 20'h2E5F3, 4'd4}, // R4 override ignored
    '{3'd1, 1'b0, 2'd0, 16'h0000, 20'h15020, 4'd5}, // R5 SP
    '{3'd2, 1'b0, 2'd0, 16'h0010, 20'h15030, 4'd5}, // R5 BP
    '{3'd3, 1'b0, 2'd0, 16'hFFFF, 20'h0F58F, 4'd3}, // R3 wrap
    '{3'd4, 1'b0, 2'd0, 16'h0A70, 20'h00000, 4'd3}, // R3 wrap exactly to zero
    '{3'd5, 1'b0, 2'd0, 16'h0001, 20'hFF591, 4'd6}, // R6 DI
    '{3'd6, 1'b0, 2'd0, 16'h0010, 20'hFF5A0, 4'd6}, // R6 spare tag
    '{3'd3, 1'b1, 2'd3, 16'h0020, 20'h10020, 4'd7}, // R7 extra
    '{3'd1, 1'b1, 2'd1, 16'h0000, 20'hFF590, 4'd7}, // R7 data
    '{3'd2, 1'b1, 2'd0, 16'h0003, 20'h25003, 4'd7}, // R7 code
    '{3'd5, 1'b1, 2'd2, 16'h0000, 20'h15020, 4'd7}  // R7 stack
  };

  task automatic chk(input string req, input logic [19:0] act, input logic [19:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %05h expected %05h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic drive(input logic [2:0] s, input logic oe, input logic [1:0] os,
                       input logic [15:0] off);
    req_valid = 1'b1; req_src = s; ovr_en = oe; ovr_sel = os; req_offset = off;
  endtask

  initial begin
    repeat (3000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [19:0] first;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 valid after reset", 20'(out_valid), 20'd0);
    chk("R1 addr after reset", out_addr, 20'h00000);
    rst = 1'b0;
    @(negedge clk);
    drive(3'd3, 1'b0, 2'd0, 16'h1234);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R1 segment cleared", out_addr, 20'h01234);
    chk("R2 valid one cycle later", 20'(out_valid), 20'd1);
    @(negedge clk);
    chk("R2 valid drops when idle", 20'(out_valid), 20'd0);
    chk("R10 addr held when idle", out_addr, 20'h01234);

    wr(2'd0, 16'h2500);
    wr(2'd1, 16'hFF59);
    wr(2'd2, 16'h1502);
    wr(2'd3, 16'h1000);

    // Table walked back to back, one request per cycle (R2)
    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].src, VEC[i].oe, VEC[i].os, VEC[i].off);
      @(negedge clk);
      chk($sformatf("R%0d vector %0d", VEC[i].tag, i), out_addr, VEC[i].exp);
      chk($sformatf("R2 valid vector %0d", i), 20'(out_valid), 20'd1);
    end
    req_valid = 1'b0;
    @(negedge clk);

    // R8 same-cycle write uses old value, later request uses new one
    wr_en = 1'b1; wr_sel = 2'd1; wr_data = 16'h0100;
    drive(3'd4, 1'b0, 2'd0, 16'h0000);
    @(negedge clk);
    wr_en = 1'b0;
    chk("R8 same-cycle old value", out_addr, 20'hFF590);
    drive(3'd4, 1'b0, 2'd0, 16'h0000);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R8 next-cycle new value", out_addr, 20'h01000);

    // R9 aliasing: 1502:0000 and 1000:5020 name the same byte
    @(negedge clk);
    drive(3'd1, 1'b0, 2'd0, 16'h0000);
    @(negedge clk);
    first = out_addr;
    chk("R9 first alias", first, 20'h15020);
    drive(3'd5, 1'b1, 2'd3, 16'h5020);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9 second alias equal", out_addr, first);
    chk("R9 second alias valid", 20'(out_valid), 20'd1);

    // R1 reset in mid-run clears the output
    rst = 1'b1;
    @(negedge clk);
    chk("R1 addr cleared by reset", out_addr, 20'h00000);
    rst = 1'b0;
    @(negedge clk);
    drive(3'd0, 1'b0, 2'd0, 16'h0042);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R1 code segment cleared", out_addr, 20'h00042);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule